// File: doc/BRIEF.md
# Registered Octal Bus Transceiver

This block moves 8-bit data between two bidirectional ports, A and B. Each direction owns a storage register clocked by its own clock: the A-to-B register takes the A bus value, and the B-to-A register takes the B bus value. For each direction, a source select decides whether the driven port carries the live value from the other port or the value held in that direction's register. One enable per direction decides whether that direction drives its target port.

Each bidirectional port appears as three signals: a data input (the resolved bus value), a data output and an output enable. The surrounding logic or testbench resolves the bus from these. With both directions enabled in live mode, each port's output is fed back through the other port into itself. The pair of buses then keeps its last value after every other driver lets go.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On a rising edge of `clk_ab` the A-to-B register loads `a_in`. On a rising edge of `clk_ba` the B-to-A register loads `b_in`.
- R2: A register loads on its clock edge whatever the values of `sel_ab`, `sel_ba`, `en_ab` and `en_ba_n`.
- R3: When a direction is enabled, its select chooses the source. `sel_ab`=0 drives `b_out` from live `a_in`, and `sel_ab`=1 drives it from the A-to-B register. `sel_ba`=0 drives `a_out` from live `b_in`, and `sel_ba`=1 drives it from the B-to-A register.
- R4: `b_oe` is 1 exactly when `en_ab` is 1 (active high). `a_oe` is 1 exactly when `en_ba_n` is 0 (active low). The two enables act independently.
- R5: A port that is not driven has its output enable at 0 and its data output at 8'h00.
- R6: The path is 8 bits wide and non-inverting in both directions: every bit pattern arrives unchanged.
- R7: With both selects at 0 and both directions enabled, a value driven externally onto one port appears on both buses. It remains on both after the external driver releases.
- R8: Driving `rst_n` low clears both registers to 8'h00 at once, without a clock edge.
- R9: The two clocks are independent. Both registers may load on coincident edges, each taking its own port's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low register clear |
| clk_ab | input | 1 | Load clock of the A-to-B register |
| clk_ba | input | 1 | Load clock of the B-to-A register |
| en_ab | input | 1 | Drive port B when 1 |
| en_ba_n | input | 1 | Drive port A when 0 |
| sel_ab | input | 1 | Source for port B: 0 live, 1 stored |
| sel_ba | input | 1 | Source for port A: 0 live, 1 stored |
| a_in | input | 8 | Resolved value on bus A |
| b_in | input | 8 | Resolved value on bus B |
| a_out | output | 8 | Value driven onto bus A |
| a_oe | output | 1 | Bus A driven by the block |
| b_out | output | 8 | Value driven onto bus B |
| b_oe | output | 1 | Bus B driven by the block |

## Verification
Eight enable and select combinations are tried with distinct data on both ports and preloaded registers whose contents differ from any live value. This shows whether each output follows the live port, the register or neither. Complementary and single-bit patterns show that no bit is inverted or swapped. Directed cases load the registers with both directions disabled and with both clocks rising together, and pulse reset with no clock. A final case releases the external driver while the live loop is closed and confirms that both buses keep the value.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic [WIDTH-1:0] q_ab, q_ba;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) q_ab <= '0;
    else        q_ab <= a_in;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) q_ba <= '0;
    else        q_ba <= b_in;

  assign b_oe  = en_ab;
  assign a_oe  = ~en_ba_n;
  assign b_out = b_oe ? (sel_ab ? q_ab : a_in) : '0;
  assign a_out = a_oe ? (sel_ba ? q_ba : b_in) : '0;

  // R1: each register holds what its port carried at the previous edge
  p_load_ab_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> (q_ab == $past(a_in)));
  p_load_ba_r1: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> (q_ba == $past(b_in)));

  // R3: stored mode presents the register on the driven port
  p_stored_b_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe && sel_ab) |-> (b_out == q_ab));
  p_stored_a_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe && sel_ba) |-> (a_out == q_ba));

  // R5: an undriven port presents zero data
  always_comb begin
    if (rst_n && a_oe == 1'b0) p_idle_a_r5: assert (a_out == '0);
    if (rst_n && b_oe == 1'b0) p_idle_b_r5: assert (b_out == '0);
  end

endmodule

// File: tb/reg_bus_xcvr_tb.sv
`timescale 1ns/1ps
module reg_bus_xcvr_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, clk_ab, clk_ba, en_ab, en_ba_n, sel_ab, sel_ba;
  logic [7:0] bus_a, bus_b, a_out, b_out;
  logic       a_oe, b_oe;
  logic       ext_a_en, ext_b_en;
  logic [7:0] ext_a, ext_b;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  reg_bus_xcvr u_dut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(bus_a), .b_in(bus_b),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  // {en_ab, en_ba_n, sel_ab, sel_ba, a, b, exp a_oe, exp b_oe, exp a_out, exp b_out}
  localparam logic [37:0] VEC [8] = '{
    {4'b0100, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},
    {4'b1100, 8'h11, 8'h22, 2'b01, 8'h00, 8'h11},
    {4'b1110, 8'h11, 8'h22, 2'b01, 8'h00, 8'hC3},
    {4'b0000, 8'h44, 8'h55, 2'b10, 8'h55, 8'h00},
    {4'b0001, 8'h44, 8'h55, 2'b10, 8'h3C, 8'h00},
    {4'b1011, 8'h66, 8'h77, 2'b11, 8'h3C, 8'hC3},
    {4'b1001, 8'h80, 8'h01, 2'b11, 8'h3C, 8'h80},
    {4'b1010, 8'hFF, 8'h00, 2'b11, 8'h00, 8'hC3}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #1;
      bus_a = ext_a_en ? ext_a : (a_oe ? a_out : bus_a);
      bus_b = ext_b_en ? ext_b : (b_oe ? b_out : bus_b);
    end
    #1;
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b);
    ext_a_en = 1'b1; ext_b_en = 1'b1; ext_a = a; ext_b = b;
    settle();
  endtask

  task automatic pulse(input logic do_ab, input logic do_ba);
    clk_ab = do_ab; clk_ba = do_ba;
    #2;
    clk_ab = 1'b0; clk_ba = 1'b0;
    #2;
    settle();
  endtask

  task automatic ctl(input logic [3:0] c);
    {en_ab, en_ba_n, sel_ab, sel_ba} = c;
    settle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
    ext_a_en = 1'b1; ext_b_en = 1'b1; ext_a = 8'h00; ext_b = 8'h00;
    bus_a = 8'h00; bus_b = 8'h00;
    #10;
    drive(8'hAA, 8'hBB);
    // R8: cleared registers seen in stored mode
    ctl(4'b1011);
    check("R8 reset a_out", a_out, 8'h00);
    check("R8 reset b_out", b_out, 8'h00);
    rst_n = 1'b1;
    #3;

    // R2: load with both directions disabled and stored mode off
    ctl(4'b0100);
    drive(8'hC3, 8'h3C);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    ctl(4'b1011);
    check("R1 R2 b_out stored", b_out, 8'hC3);
    check("R1 R2 a_out stored", a_out, 8'h3C);

    // table: R3 R4 R5 R6
    for (int k = 0; k < 8; k++) begin
      ctl(VEC[k][37:34]);
      drive(VEC[k][33:26], VEC[k][25:18]);
      check("R4 a_oe", {7'd0, a_oe}, {7'd0, VEC[k][17]});
      check("R4 b_oe", {7'd0, b_oe}, {7'd0, VEC[k][16]});
      check("R3 R5 R6 a_out", a_out, VEC[k][15:8]);
      check("R3 R5 R6 b_out", b_out, VEC[k][7:0]);
    end

    // R9: coincident edges load both registers
    drive(8'h5A, 8'hA5);
    pulse(1'b1, 1'b1);
    drive(8'h00, 8'h00);
    ctl(4'b1011);
    check("R9 b_out", b_out, 8'h5A);
    check("R9 a_out", a_out, 8'hA5);

    // R1: only the clocked register changes
    drive(8'h0F, 8'hF0);
    pulse(1'b1, 1'b0);
    check("R1 b_out after clk_ab", b_out, 8'h0F);
    check("R1 a_out unchanged", a_out, 8'hA5);

    // R8: asynchronous clear without a clock
    rst_n = 1'b0;
    settle();
    check("R8 async a_out", a_out, 8'h00);
    check("R8 async b_out", b_out, 8'h00);
    rst_n = 1'b1;
    #3;

    // R7: live loop holds the bus after the driver releases
    ctl(4'b1000);
    ext_b_en = 1'b0;
    ext_a_en = 1'b1; ext_a = 8'h96;
    settle();
    check("R7 bus_b driven", bus_b, 8'h96);
    ext_a_en = 1'b0;
    settle();
    settle();
    check("R7 bus_a held", bus_a, 8'h96);
    check("R7 bus_b held", bus_b, 8'h96);
    check("R7 a_out loop", a_out, 8'h96);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule